// File: doc/BRIEF.md
# Key-protected control register file

This block is a bank of 32-bit control and status words behind a word-addressed request port. A request is one cycle long: `req_valid` is high, `req_write` selects write or read, and `req_addr` gives the word index into a 4 KiB space. Read data, a read-valid strobe and an error pulse come back one cycle later.

A lock flag guards the bank. Software clears it by writing a 16-bit key to one key register and sets it again with a different key written to a second key register. While the flag is set, only the scratch bit and the two key registers accept writes. Every offset belongs to one access class: read-write, read-only, write-only or unmapped. An illegal access still completes, but it raises the error pulse. A write-side bit in the reset-control word asks the rest of the chip for a system reset. A small general-purpose window of read-write words sits in block-RAM-style storage.

Top module: `ctlreg_bank`

## Requirements
- R1: A read request at clock edge N sets `rsp_valid` high for exactly the cycle after edge N, with `rsp_rdata` valid in that cycle. Write requests and idle cycles leave `rsp_valid` low.
- R2: A write to byte offset 0x004 sets the lock flag when bits 15:0 of the data equal 0x767B. Any other value leaves the flag unchanged. This write is allowed while locked.
- R3: A write to byte offset 0x008 clears the lock flag when bits 15:0 of the data equal 0xDF0D. Any other value leaves the flag unchanged.
- R4: After reset the lock flag is 1. A read of byte offset 0x00C returns the flag in bit 0, with bits 31:1 zero.
- R5: While locked, a write to any offset other than 0x000, 0x004 and 0x008 changes no stored word and raises `rsp_err`.
- R6: Byte offset 0x000 keeps only bit 0 of the written data, reads back with bits 31:1 zero, and is writable whether or not the bank is locked.
- R7: The read-only offsets 0x00C, 0x10C and 0x25C reject writes with `rsp_err`, and their read value does not change.
- R8: A read of a write-only offset (0x004, 0x008) or of an unmapped offset returns zero and raises `rsp_err`.
- R9: `rsp_err` is high for one cycle, the cycle after the offending request. A legal access and an idle cycle leave it low.
- R10: An accepted write to byte offset 0x200 with data bit 0 set raises `sys_rst_req` for the one cycle after the request. Bit 0 clear, or the bank locked, gives no request.
- R11: Reset loads 0x0001A008 into offsets 0x100, 0x104 and 0x108, 0x0000003F into 0x10C, 0x00003F03 into 0x154, 0x00000001 into 0x25C, and zero into 0x000 and 0x200.
- R12: The general window from byte offset 0x700 through 0x73C stores full 32-bit words when the bank is unlocked and reads them back, including during back-to-back accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (10) | Word index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Illegal-access pulse, one cycle after the request |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
On every cycle the assertions check several timing rules. The key registers move the lock flag only on the matching value, and the flag holds when no key write comes. A locked write outside the exempt offsets always produces an error. An error or a read-valid never appears without a request the cycle before, and a reset request only follows an unlocked write with bit 0 set. Some behaviour only the bench's scenarios can show: that dropped writes really leave stored words untouched, the reset values, the scratch-bit masking, the zero data of write-only and unmapped reads, and the read-back of the general window. The bench shows these by comparing every cycle against a behavioural model of the map.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  localparam int DW     = 32;
  localparam int NFIX   = 8;
  localparam int FIX_IW = $clog2(NFIX);

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_RW   = 2'd1,
    ACC_RO   = 2'd2,
    ACC_WO   = 2'd3
  } acc_e;

  // slots of the flop-based fixed registers
  localparam logic [FIX_IW-1:0] SL_SCRATCH = 3'd0;
  localparam logic [FIX_IW-1:0] SL_PLL0    = 3'd1;
  localparam logic [FIX_IW-1:0] SL_PLL1    = 3'd2;
  localparam logic [FIX_IW-1:0] SL_PLL2    = 3'd3;
  localparam logic [FIX_IW-1:0] SL_PLLSTAT = 3'd4;
  localparam logic [FIX_IW-1:0] SL_UARTCLK = 3'd5;
  localparam logic [FIX_IW-1:0] SL_RSTCTL  = 3'd6;
  localparam logic [FIX_IW-1:0] SL_BOOT    = 3'd7;

  function automatic logic [DW-1:0] fix_reset(int s);
    case (s)
      1, 2, 3: fix_reset = 32'h0001_A008;
      4:       fix_reset = 32'h0000_003F;
      5:       fix_reset = 32'h0000_3F03;
      7:       fix_reset = 32'h0000_0001;
      default: fix_reset = '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] fix_mask(int s);
    fix_mask = (s == 0) ? 32'h0000_0001 : '1;
  endfunction

  function automatic acc_e fix_class(int s);
    case (s)
      4, 7:    fix_class = ACC_RO;
      default: fix_class = ACC_RW;
    endcase
  endfunction

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
  import ctlreg_pkg::*;
#(
  parameter int AW        = 10,
  parameter int GEN_BASE  = 448,
  parameter int GEN_WORDS = 16,
  localparam int GIW      = $clog2(GEN_WORDS)
) (
  input  logic [AW-1:0]     addr,
  output acc_e              cls,
  output logic              exempt,
  output logic              fix_hit,
  output logic [FIX_IW-1:0] fix_idx,
  output logic              is_lock,
  output logic              is_unlock,
  output logic              is_stat,
  output logic              gen_hit,
  output logic [GIW-1:0]    gen_idx
);

  localparam logic [AW-1:0] A_SCRATCH = AW'(0);
  localparam logic [AW-1:0] A_LOCK    = AW'(12'h004 >> 2);
  localparam logic [AW-1:0] A_UNLOCK  = AW'(12'h008 >> 2);
  localparam logic [AW-1:0] A_STAT    = AW'(12'h00C >> 2);
  localparam logic [AW-1:0] A_PLL0    = AW'(12'h100 >> 2);
  localparam logic [AW-1:0] A_PLL1    = AW'(12'h104 >> 2);
  localparam logic [AW-1:0] A_PLL2    = AW'(12'h108 >> 2);
  localparam logic [AW-1:0] A_PLLSTAT = AW'(12'h10C >> 2);
  localparam logic [AW-1:0] A_UARTCLK = AW'(12'h154 >> 2);
  localparam logic [AW-1:0] A_RSTCTL  = AW'(12'h200 >> 2);
  localparam logic [AW-1:0] A_BOOT    = AW'(12'h25C >> 2);

  logic in_gen;

  assign in_gen  = (int'(addr) >= GEN_BASE) && (int'(addr) < GEN_BASE + GEN_WORDS);
  assign gen_idx = GIW'(addr - AW'(GEN_BASE));

  always_comb begin
    cls       = ACC_NONE;
    exempt    = 1'b0;
    fix_hit   = 1'b0;
    fix_idx   = '0;
    is_lock   = 1'b0;
    is_unlock = 1'b0;
    is_stat   = 1'b0;
    gen_hit   = 1'b0;
    case (addr)
      A_SCRATCH: begin fix_hit = 1'b1; fix_idx = SL_SCRATCH; exempt = 1'b1; end
      A_LOCK:    begin cls = ACC_WO; is_lock = 1'b1; exempt = 1'b1; end
      A_UNLOCK:  begin cls = ACC_WO; is_unlock = 1'b1; exempt = 1'b1; end
      A_STAT:    begin cls = ACC_RO; is_stat = 1'b1; end
      A_PLL0:    begin fix_hit = 1'b1; fix_idx = SL_PLL0; end
      A_PLL1:    begin fix_hit = 1'b1; fix_idx = SL_PLL1; end
      A_PLL2:    begin fix_hit = 1'b1; fix_idx = SL_PLL2; end
      A_PLLSTAT: begin fix_hit = 1'b1; fix_idx = SL_PLLSTAT; end
      A_UARTCLK: begin fix_hit = 1'b1; fix_idx = SL_UARTCLK; end
      A_RSTCTL:  begin fix_hit = 1'b1; fix_idx = SL_RSTCTL; end
      A_BOOT:    begin fix_hit = 1'b1; fix_idx = SL_BOOT; end
      default:   ;
    endcase
    if (fix_hit) cls = fix_class(int'(fix_idx));
    if (in_gen) begin
      gen_hit = 1'b1;
      cls     = ACC_RW;
    end
  end

endmodule

// File: rtl/ctlreg_lock.sv
module ctlreg_lock #(
  parameter int             KEY_W      = 16,
  parameter logic [KEY_W-1:0] LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_wr,
  input  logic             unlock_wr,
  input  logic [KEY_W-1:0] key,
  output logic             locked
);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b1;
    end else if (lock_wr && key == LOCK_KEY) begin
      locked <= 1'b1;
    end else if (unlock_wr && key == UNLOCK_KEY) begin
      locked <= 1'b0;
    end
  end

  // R2
  lock_set_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_wr && !unlock_wr && key == LOCK_KEY) |=> locked);

  // R3
  unlock_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (unlock_wr && !lock_wr && key == UNLOCK_KEY) |=> !locked);

  // R2
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!lock_wr && !unlock_wr) |=> $stable(locked));

endmodule

// File: rtl/ctlreg_fixed.sv
module ctlreg_fixed
  import ctlreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [FIX_IW-1:0] idx,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);

  logic [DW-1:0] regs [NFIX];

  always_ff @(posedge clk) begin
    for (int s = 0; s < NFIX; s++) begin
      if (rst) begin
        regs[s] <= fix_reset(s);
      end else if (we && idx == FIX_IW'(s) && fix_class(s) == ACC_RW) begin
        regs[s] <= wdata & fix_mask(s);
      end
    end
  end

  assign rdata = regs[idx];

endmodule

// File: rtl/ctlreg_ram.sv
module ctlreg_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    rdata <= mem[idx];
  end

endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int AW        = 10,
  parameter int GEN_BASE  = 448,
  parameter int GEN_WORDS = 16,
  parameter int KEY_W     = 16,
  parameter logic [KEY_W-1:0] LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D,
  localparam int GIW      = $clog2(GEN_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_err,
  output logic          sys_rst_req
);

  acc_e              cls;
  logic              exempt, fix_hit, is_lock, is_unlock, is_stat, gen_hit;
  logic [FIX_IW-1:0] fix_idx;
  logic [GIW-1:0]    gen_idx;
  logic              locked;
  logic              wr_req, rd_req, wr_legal, wr_accept, acc_err;
  logic [DW-1:0]     fix_rdata, ram_rdata;
  logic [DW-1:0]     side_q;
  logic              sel_ram_q;

  ctlreg_decode #(.AW(AW), .GEN_BASE(GEN_BASE), .GEN_WORDS(GEN_WORDS)) u_dec (
    .addr(req_addr), .cls(cls), .exempt(exempt), .fix_hit(fix_hit), .fix_idx(fix_idx),
    .is_lock(is_lock), .is_unlock(is_unlock), .is_stat(is_stat),
    .gen_hit(gen_hit), .gen_idx(gen_idx)
  );

  assign wr_req    = req_valid && req_write;
  assign rd_req    = req_valid && !req_write;
  assign wr_legal  = (cls == ACC_RW) || (cls == ACC_WO);
  assign wr_accept = wr_req && wr_legal && (exempt || !locked);
  assign acc_err   = (wr_req && !wr_accept) ||
                     (rd_req && (cls == ACC_WO || cls == ACC_NONE));

  ctlreg_lock #(.KEY_W(KEY_W), .LOCK_KEY(LOCK_KEY), .UNLOCK_KEY(UNLOCK_KEY)) u_lock (
    .clk(clk), .rst(rst),
    .lock_wr(wr_accept && is_lock), .unlock_wr(wr_accept && is_unlock),
    .key(req_wdata[KEY_W-1:0]), .locked(locked)
  );

  ctlreg_fixed u_fix (
    .clk(clk), .rst(rst), .we(wr_accept && fix_hit), .idx(fix_idx),
    .wdata(req_wdata), .rdata(fix_rdata)
  );

  ctlreg_ram #(.DW(DW), .DEPTH(GEN_WORDS)) u_ram (
    .clk(clk), .we(wr_accept && gen_hit), .idx(gen_idx),
    .wdata(req_wdata), .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_err     <= 1'b0;
      sys_rst_req <= 1'b0;
      sel_ram_q   <= 1'b0;
      side_q      <= '0;
    end else begin
      rsp_valid   <= rd_req;
      rsp_err     <= acc_err;
      sys_rst_req <= wr_accept && fix_hit && (fix_idx == SL_RSTCTL) && req_wdata[0];
      sel_ram_q   <= rd_req && gen_hit;
      if (rd_req && is_stat)      side_q <= {{(DW-1){1'b0}}, locked};
      else if (rd_req && fix_hit) side_q <= fix_rdata;
      else                        side_q <= '0;
    end
  end

  assign rsp_rdata = sel_ram_q ? ram_rdata : side_q;

  // R1
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  // R5
  locked_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && locked && !exempt) |=> rsp_err);

  // R9
  err_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_err && !rsp_valid));

  // R10
  rst_req_src_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> $past(req_valid && req_write && !locked && req_wdata[0]));

endmodule

// File: tb/tb_ctlreg_bank.sv
`timescale 1ns/1ps
module tb_ctlreg_bank;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          rsp_valid, rsp_err, sys_rst_req;
  logic [31:0]   rsp_rdata;

  int checks = 0;
  int errors = 0;

  logic [31:0] model [int];
  bit          m_lock;
  bit          e_valid, e_err, e_rst;
  logic [31:0] e_data;

  always #10 clk = ~clk;

  ctlreg_bank dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .sys_rst_req(sys_rst_req)
  );

  // 0 unmapped, 1 read-write, 2 read-only, 3 write-only
  function automatic int cls_of(int a);
    if (a >= 'h700 && a <= 'h73C) return 1;
    case (a)
      'h000, 'h100, 'h104, 'h108, 'h154, 'h200: return 1;
      'h00C, 'h10C, 'h25C: return 2;
      'h004, 'h008: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    model.delete();
    model['h000] = 32'h0;
    model['h100] = 32'h0001_A008;
    model['h104] = 32'h0001_A008;
    model['h108] = 32'h0001_A008;
    model['h10C] = 32'h0000_003F;
    model['h154] = 32'h0000_3F03;
    model['h200] = 32'h0;
    model['h25C] = 32'h0000_0001;
    m_lock = 1'b1;
  endtask

  task automatic compare(string tag);
    check(tag, "rsp_valid", {31'b0, rsp_valid}, {31'b0, e_valid});
    check(tag, "rsp_err", {31'b0, rsp_err}, {31'b0, e_err});
    check(tag, "sys_rst_req", {31'b0, sys_rst_req}, {31'b0, e_rst});
    if (e_valid) check(tag, "rsp_rdata", rsp_rdata, e_data);
  endtask

  task automatic access(bit w, int a, logic [31:0] d, string tag);
    int c;
    bit ex, acc;
    c  = cls_of(a);
    ex = (a == 'h000 || a == 'h004 || a == 'h008);
    e_rst = 1'b0;
    e_data = '0;
    if (w) begin
      acc = (c == 1 || c == 3) && (ex || !m_lock);
      e_valid = 1'b0;
      e_err = !acc;
      if (acc) begin
        if (a == 'h004) begin
          if (d[15:0] == 16'h767B) m_lock = 1'b1;
        end else if (a == 'h008) begin
          if (d[15:0] == 16'hDF0D) m_lock = 1'b0;
        end else if (a == 'h000) begin
          model[a] = d & 32'h1;
        end else begin
          model[a] = d;
          if (a == 'h200) e_rst = d[0];
        end
      end
    end else begin
      e_valid = 1'b1;
      e_err = (c == 0 || c == 3);
      if (a == 'h00C) e_data = {31'b0, m_lock};
      else if (c == 1 || c == 2) e_data = model.exists(a) ? model[a] : 32'h0;
    end
    req_valid = 1'b1;
    req_write = w;
    req_addr  = AW'(a >> 2);
    req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    compare(tag);
  endtask

  task automatic idle(int n, string tag);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      e_valid = 1'b0; e_err = 1'b0; e_rst = 1'b0;
      @(posedge clk);
      @(negedge clk);
      compare(tag);
    end
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    idle(2, "R9 reset idle");

    // R4 / R11 reset state
    access(0, 'h00C, 0, "R4 status after reset");
    access(0, 'h100, 0, "R11 pll0 reset");
    access(0, 'h104, 0, "R11 pll1 reset");
    access(0, 'h108, 0, "R11 pll2 reset");
    access(0, 'h10C, 0, "R11 pll status reset");
    access(0, 'h154, 0, "R11 uart clk reset");
    access(0, 'h25C, 0, "R11 boot reset");
    access(0, 'h200, 0, "R11 rstctl reset");
    access(0, 'h000, 0, "R11 scratch reset");

    // R5 locked writes dropped
    access(1, 'h100, 32'hDEAD_BEEF, "R5 locked write pll0");
    access(0, 'h100, 0, "R5 pll0 unchanged");
    access(1, 'h200, 32'h1, "R10 locked rstctl no request");
    access(1, 'h700, 32'h1111_2222, "R5 locked write window");
    access(1, 'h00C, 32'h0, "R5 locked write status");

    // R6 scratch bit
    access(1, 'h000, 32'hFFFF_FFFF, "R6 scratch write while locked");
    access(0, 'h000, 0, "R6 scratch reads bit0");
    access(1, 'h000, 32'hFFFF_FFFE, "R6 scratch clear");
    access(0, 'h000, 0, "R6 scratch cleared");

    // R3 unlock keys
    access(1, 'h008, 32'h0000_DF0E, "R3 wrong unlock key");
    access(0, 'h00C, 0, "R3 still locked");
    access(1, 'h004, 32'h0000_DF0D, "R2 unlock key at lock offset");
    access(0, 'h00C, 0, "R2 still locked");
    access(1, 'h008, 32'hABCD_DF0D, "R3 unlock");
    access(0, 'h00C, 0, "R3 unlocked status");

    // unlocked writes
    access(1, 'h100, 32'h1234_5678, "R5 unlocked write pll0");
    access(0, 'h100, 0, "R5 pll0 readback");
    access(1, 'h154, 32'h0000_0A51, "R11 uart clk write");
    access(0, 'h154, 0, "R11 uart clk readback");

    // R7 read-only
    access(1, 'h10C, 32'h0, "R7 write pll status");
    access(0, 'h10C, 0, "R7 pll status unchanged");
    access(1, 'h25C, 32'hFFFF_FFFF, "R7 write boot");
    access(0, 'h25C, 0, "R7 boot unchanged");
    access(1, 'h00C, 32'h1, "R7 write status");
    access(0, 'h00C, 0, "R7 status unchanged");

    // R8 write-only and unmapped
    access(0, 'h004, 0, "R8 read lock reg");
    access(0, 'h008, 0, "R8 read unlock reg");
    access(0, 'h010, 0, "R8 read unmapped");
    access(0, 'hFFC, 0, "R8 read top unmapped");
    access(1, 'h800, 32'h5, "R9 write unmapped");
    access(0, 'h740, 0, "R8 read past window");

    // R10 reset request
    access(1, 'h200, 32'h0000_0001, "R10 soft reset request");
    idle(1, "R10 pulse ends");
    access(1, 'h200, 32'h0000_0002, "R10 bit0 clear no request");
    access(0, 'h200, 0, "R10 rstctl readback");
    access(1, 'h200, 32'hFFFF_FFFF, "R10 back-to-back request a");
    access(1, 'h200, 32'h0000_0003, "R10 back-to-back request b");

    // R12 general window, back-to-back
    for (int i = 0; i < 16; i++)
      access(1, 'h700 + 4 * i, 32'hA5A5_0000 ^ (i * 32'h0101_0101), "R12 window write");
    for (int i = 15; i >= 0; i--)
      access(0, 'h700 + 4 * i, 0, "R12 window read");
    access(1, 'h73C, 32'h0, "R12 window top write");
    access(0, 'h73C, 0, "R12 window top read");
    access(0, 'h700, 0, "R12 window base read");

    // R2 relock
    access(1, 'h004, 32'h0000_767C, "R2 wrong lock key");
    access(0, 'h00C, 0, "R2 still unlocked");
    access(1, 'h004, 32'hFFFF_767B, "R2 lock");
    access(0, 'h00C, 0, "R2 relocked status");
    access(1, 'h704, 32'h0BAD_0BAD, "R5 relocked window write");
    access(0, 'h704, 0, "R5 window unchanged");
    access(1, 'h200, 32'h1, "R10 relocked no request");
    idle(2, "R1 idle no valid");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule